// File: doc/BRIEF.md
# Split-Bus Local Memory Router

This block sits between a processor with separate code and system buses and the memories close to it. The 32-bit address space is divided at a fixed split address. Everything below the split belongs to the code bus and everything at or above it belongs to the system bus. Each bus has its own local SRAM bank. The lower bank ends just below the split and is reached from the code bus. The upper bank starts at the split and is reached from the system bus. Local accesses complete with zero wait states.

Code accesses that fall outside the lower bank are handled in one of two ways. If the access is cacheable and the cache reports a hit, it completes locally from the cache data input. Otherwise it goes out on a dedicated outbound code master port. System accesses outside the upper bank go out on a separate outbound system master port.

A third inbound port, the backdoor, lets every other bus master read and write both banks. When the backdoor and a processor bus want the same bank in the same cycle, the processor bus wins. The backdoor is then guaranteed the bank in the following cycle.

Every port uses a single-beat request/ready handshake. The master raises `*_req` and holds the address, direction, size and write data stable. The transfer completes on the rising edge where `*_req` and `*_ready` are both high. Read data and the error flag are valid during that cycle. Size encodings are 0 for a byte, 1 for a halfword and 2 for a word. Write data sits on its natural byte lanes, as it does on an AHB-Lite bus.

Top module: `lmr_router`

## Requirements
- R1: After reset, with no request pending, `code_ready`, `sys_ready` and `bd_ready` are high, and `cmo_req` and `smo_req` are low.
- R2: A code request whose address lies in the lower bank window (`SPLIT-BANK_BYTES` to `SPLIT-1`) completes with zero wait states. Its write updates only the byte lanes chosen by size and address: size 0 writes lane `addr[1:0]`, size 1 writes lanes 1:0 when `addr[1]` is 0 and lanes 3:2 when it is 1, and size 2 writes all four lanes. A later word read returns the merged word. No outbound request results.
- R3: A system request whose address lies in the upper bank window (`SPLIT` to `SPLIT+BANK_BYTES-1`) completes with zero wait states and follows the same lane rules. No outbound request results.
- R4: A code request below the split and outside the lower window, with `code_cacheable` and `code_cache_hit` both high, completes with zero wait states and returns `code_cache_rdata`. Nothing goes to the outbound code port.
- R5: A code request below the split and outside the lower window that misses the cache or is non-cacheable is sent to the outbound code port. Address, direction, size and write data are preserved. The inbound port completes two cycles plus the outbound wait states after the request. The outbound read data and error flag are returned unchanged.
- R6: A system request at or above the split and outside the upper window is sent to the outbound system port, with the same preservation, timing and response rules as R5.
- R7: The backdoor port reads and writes both banks. Its storage is shared with the processor ports, and an uncontended backdoor access completes with zero wait states.
- R8: If a processor bus and the backdoor request the same bank in the same cycle, the processor bus completes first. If the backdoor is still requesting that bank in the next cycle, the backdoor is granted and the processor bus waits that one cycle.
- R9: A backdoor request outside both bank windows completes with zero wait states and the error flag set. Nothing is forwarded.
- R10: A code request at or above the split, or a system request below it, completes with zero wait states and the error flag set. Nothing is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_req | input | 1 | Code bus transfer request |
| code_addr | input | 32 | Code bus byte address |
| code_write | input | 1 | Code bus write (1) or read (0) |
| code_size | input | 3 | Code bus transfer size |
| code_wdata | input | 32 | Code bus write data |
| code_cacheable | input | 1 | Code access may be served by the cache |
| code_cache_hit | input | 1 | Cache lookup hit for the code address |
| code_cache_rdata | input | 32 | Cache read data |
| code_ready | output | 1 | Code transfer completes this cycle |
| code_rdata | output | 32 | Code read data |
| code_err | output | 1 | Code error response |
| sys_req | input | 1 | System bus transfer request |
| sys_addr | input | 32 | System bus byte address |
| sys_write | input | 1 | System bus write |
| sys_size | input | 3 | System bus transfer size |
| sys_wdata | input | 32 | System bus write data |
| sys_ready | output | 1 | System transfer completes this cycle |
| sys_rdata | output | 32 | System read data |
| sys_err | output | 1 | System error response |
| bd_req | input | 1 | Backdoor transfer request |
| bd_addr | input | 32 | Backdoor byte address |
| bd_write | input | 1 | Backdoor write |
| bd_size | input | 3 | Backdoor transfer size |
| bd_wdata | input | 32 | Backdoor write data |
| bd_ready | output | 1 | Backdoor transfer completes this cycle |
| bd_rdata | output | 32 | Backdoor read data |
| bd_err | output | 1 | Backdoor error response |
| cmo_req | output | 1 | Outbound code master request |
| cmo_addr | output | 32 | Outbound code master address |
| cmo_write | output | 1 | Outbound code master write |
| cmo_size | output | 3 | Outbound code master size |
| cmo_wdata | output | 32 | Outbound code master write data |
| cmo_ready | input | 1 | Outbound code slave ready |
| cmo_rdata | input | 32 | Outbound code slave read data |
| cmo_err | input | 1 | Outbound code slave error |
| smo_req | output | 1 | Outbound system master request |
| smo_addr | output | 32 | Outbound system master address |
| smo_write | output | 1 | Outbound system master write |
| smo_size | output | 3 | Outbound system master size |
| smo_wdata | output | 32 | Outbound system master write data |
| smo_ready | input | 1 | Outbound system slave ready |
| smo_rdata | input | 32 | Outbound system slave read data |
| smo_err | input | 1 | Outbound system slave error |

## Verification
The assertions assume that every master keeps its request and attributes unchanged until the cycle its ready is high. They also assume that outbound slaves keep ready low while no request is shown. Under these assumptions:
- a local code or system access can never coincide with a forwarded transfer on the same bus;
- a backdoor request that loses arbitration and is still present in the next cycle must be granted.

The bench drives every inbound port through tasks that hold all attributes until completion and drop the request only after the completing edge. Its outbound slave models raise ready only while a request is present, after a programmable number of wait cycles.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    localparam int unsigned LMR_AW = 32;
    localparam int unsigned LMR_DW = 32;

    typedef enum logic [1:0] {
        FW_IDLE  = 2'd0,
        FW_ISSUE = 2'd1,
        FW_RESP  = 2'd2
    } fw_state_e;

    typedef struct packed {
        fw_state_e         state;
        logic [LMR_AW-1:0] addr;
        logic              write;
        logic [2:0]        size;
        logic [LMR_DW-1:0] wdata;
        logic [LMR_DW-1:0] rdata;
        logic              err;
    } fw_regs_t;

    typedef struct packed {
        logic owed;
    } arb_regs_t;

    // unsigned window test: base <= a < base+len, wrap-safe
    function automatic logic in_win(logic [LMR_AW-1:0] a,
                                    logic [LMR_AW-1:0] base,
                                    logic [LMR_AW-1:0] len);
        return (a - base) < len;
    endfunction

    function automatic logic [3:0] lane_mask(logic [2:0] size, logic [1:0] a);
        logic [3:0] m;
        case (size)
            3'd0:    m = 4'b0001 << a;
            3'd1:    m = a[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lmr_sram_bank.sv
module lmr_sram_bank #(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [3:0]       strb,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [31:0] mem [DEPTH];

    for (genvar l = 0; l < 4; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && strb[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/lmr_bank_arb.sv
module lmr_bank_arb
    import lmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic bd_req,
    output logic cpu_gnt,
    output logic bd_gnt
);
    arb_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        cpu_gnt = cpu_req && !(bd_req && r_q.owed);
        bd_gnt  = bd_req && !cpu_gnt;
        r_d.owed = bd_req && !bd_gnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R8
    bd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_req && !bd_gnt) |=> (!bd_req || bd_gnt));

    // R8
    cpu_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_gnt) |-> bd_gnt);

endmodule

// File: rtl/lmr_fwd.sv
module lmr_fwd
    import lmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req,
    input  logic [LMR_AW-1:0] in_addr,
    input  logic              in_write,
    input  logic [2:0]        in_size,
    input  logic [LMR_DW-1:0] in_wdata,
    output logic              in_ready,
    output logic [LMR_DW-1:0] in_rdata,
    output logic              in_err,
    output logic              out_req,
    output logic [LMR_AW-1:0] out_addr,
    output logic              out_write,
    output logic [2:0]        out_size,
    output logic [LMR_DW-1:0] out_wdata,
    input  logic              out_ready,
    input  logic [LMR_DW-1:0] out_rdata,
    input  logic              out_err
);
    fw_regs_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        case (f_q.state)
            FW_IDLE: begin
                if (in_req) begin
                    f_d.addr  = in_addr;
                    f_d.write = in_write;
                    f_d.size  = in_size;
                    f_d.wdata = in_wdata;
                    f_d.state = FW_ISSUE;
                end
            end
            FW_ISSUE: begin
                if (out_ready) begin
                    f_d.rdata = out_rdata;
                    f_d.err   = out_err;
                    f_d.state = FW_RESP;
                end
            end
            default: f_d.state = FW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: FW_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign out_req   = (f_q.state == FW_ISSUE);
    assign out_addr  = f_q.addr;
    assign out_write = f_q.write;
    assign out_size  = f_q.size;
    assign out_wdata = f_q.wdata;
    assign in_ready  = (f_q.state == FW_RESP);
    assign in_rdata  = f_q.rdata;
    assign in_err    = f_q.err;

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ready) |=> (out_req && $stable(out_addr) && $stable(out_wdata)));

    // R5
    resp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && out_ready) |=> (in_ready && in_err == $past(out_err)
                                    && in_rdata == $past(out_rdata)));

endmodule

// File: rtl/lmr_router.sv
module lmr_router
    import lmr_pkg::*;
#(
    parameter int unsigned    BANK_AW = 10,
    parameter logic [31:0]    SPLIT   = 32'h2000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        code_req,
    input  logic [31:0] code_addr,
    input  logic        code_write,
    input  logic [2:0]  code_size,
    input  logic [31:0] code_wdata,
    input  logic        code_cacheable,
    input  logic        code_cache_hit,
    input  logic [31:0] code_cache_rdata,
    output logic        code_ready,
    output logic [31:0] code_rdata,
    output logic        code_err,
    input  logic        sys_req,
    input  logic [31:0] sys_addr,
    input  logic        sys_write,
    input  logic [2:0]  sys_size,
    input  logic [31:0] sys_wdata,
    output logic        sys_ready,
    output logic [31:0] sys_rdata,
    output logic        sys_err,
    input  logic        bd_req,
    input  logic [31:0] bd_addr,
    input  logic        bd_write,
    input  logic [2:0]  bd_size,
    input  logic [31:0] bd_wdata,
    output logic        bd_ready,
    output logic [31:0] bd_rdata,
    output logic        bd_err,
    output logic        cmo_req,
    output logic [31:0] cmo_addr,
    output logic        cmo_write,
    output logic [2:0]  cmo_size,
    output logic [31:0] cmo_wdata,
    input  logic        cmo_ready,
    input  logic [31:0] cmo_rdata,
    input  logic        cmo_err,
    output logic        smo_req,
    output logic [31:0] smo_addr,
    output logic        smo_write,
    output logic [2:0]  smo_size,
    output logic [31:0] smo_wdata,
    input  logic        smo_ready,
    input  logic [31:0] smo_rdata,
    input  logic        smo_err
);
    localparam int unsigned NBANK      = 2;
    localparam logic [31:0] BANK_BYTES = 32'(4) << BANK_AW;
    localparam logic [31:0] LO_BASE    = SPLIT - BANK_BYTES;
    localparam logic [31:0] HI_BASE    = SPLIT;

    // address decode
    logic c_space, c_lo, c_hit;
    logic c_rt_bank, c_rt_bad, c_rt_cache, c_rt_out;
    logic s_space, s_up, s_rt_bank, s_rt_bad, s_rt_out;
    logic b_lo, b_up, b_rt_bad;

    always_comb begin
        c_space    = code_addr < SPLIT;
        c_lo       = in_win(code_addr, LO_BASE, BANK_BYTES);
        c_hit      = code_cacheable && code_cache_hit;
        c_rt_bank  = code_req && c_lo;
        c_rt_bad   = code_req && !c_space;
        c_rt_cache = code_req && c_space && !c_lo && c_hit;
        c_rt_out   = code_req && c_space && !c_lo && !c_hit;

        s_space    = sys_addr >= SPLIT;
        s_up       = in_win(sys_addr, HI_BASE, BANK_BYTES);
        s_rt_bank  = sys_req && s_up;
        s_rt_bad   = sys_req && !s_space;
        s_rt_out   = sys_req && s_space && !s_up;

        b_lo       = in_win(bd_addr, LO_BASE, BANK_BYTES);
        b_up       = in_win(bd_addr, HI_BASE, BANK_BYTES);
        b_rt_bad   = bd_req && !b_lo && !b_up;
    end

    // per-bank processor side, index 0 = lower (code), 1 = upper (system)
    logic [NBANK-1:0] bk_cpu_req, bk_bd_req, bk_cpu_gnt, bk_bd_gnt;
    logic [31:0]      bk_cpu_addr  [NBANK];
    logic             bk_cpu_write [NBANK];
    logic [2:0]       bk_cpu_size  [NBANK];
    logic [31:0]      bk_cpu_wdata [NBANK];
    logic [31:0]      bk_rdata     [NBANK];

    always_comb begin
        bk_cpu_req      = {s_rt_bank, c_rt_bank};
        bk_bd_req       = {bd_req && b_up, bd_req && b_lo};
        bk_cpu_addr[0]  = code_addr;
        bk_cpu_write[0] = code_write;
        bk_cpu_size[0]  = code_size;
        bk_cpu_wdata[0] = code_wdata;
        bk_cpu_addr[1]  = sys_addr;
        bk_cpu_write[1] = sys_write;
        bk_cpu_size[1]  = sys_size;
        bk_cpu_wdata[1] = sys_wdata;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [31:0] m_addr, m_wdata;
        logic [2:0]  m_size;
        logic        m_we;

        lmr_bank_arb u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .cpu_req (bk_cpu_req[b]),
            .bd_req  (bk_bd_req[b]),
            .cpu_gnt (bk_cpu_gnt[b]),
            .bd_gnt  (bk_bd_gnt[b])
        );

        always_comb begin
            if (bk_bd_gnt[b]) begin
                m_addr  = bd_addr;
                m_size  = bd_size;
                m_wdata = bd_wdata;
            end else begin
                m_addr  = bk_cpu_addr[b];
                m_size  = bk_cpu_size[b];
                m_wdata = bk_cpu_wdata[b];
            end
            m_we = (bk_cpu_gnt[b] && bk_cpu_write[b]) || (bk_bd_gnt[b] && bd_write);
        end

        lmr_sram_bank #(.IDX_W(BANK_AW)) u_bank (
            .clk   (clk),
            .we    (m_we),
            .strb  (lane_mask(m_size, m_addr[1:0])),
            .idx   (m_addr[BANK_AW+1:2]),
            .wdata (m_wdata),
            .rdata (bk_rdata[b])
        );
    end

    // outbound forwarders
    logic        cf_ready, cf_err, sf_ready, sf_err;
    logic [31:0] cf_rdata, sf_rdata;

    lmr_fwd u_code_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_req    (c_rt_out),
        .in_addr   (code_addr),
        .in_write  (code_write),
        .in_size   (code_size),
        .in_wdata  (code_wdata),
        .in_ready  (cf_ready),
        .in_rdata  (cf_rdata),
        .in_err    (cf_err),
        .out_req   (cmo_req),
        .out_addr  (cmo_addr),
        .out_write (cmo_write),
        .out_size  (cmo_size),
        .out_wdata (cmo_wdata),
        .out_ready (cmo_ready),
        .out_rdata (cmo_rdata),
        .out_err   (cmo_err)
    );

    lmr_fwd u_sys_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_req    (s_rt_out),
        .in_addr   (sys_addr),
        .in_write  (sys_write),
        .in_size   (sys_size),
        .in_wdata  (sys_wdata),
        .in_ready  (sf_ready),
        .in_rdata  (sf_rdata),
        .in_err    (sf_err),
        .out_req   (smo_req),
        .out_addr  (smo_addr),
        .out_write (smo_write),
        .out_size  (smo_size),
        .out_wdata (smo_wdata),
        .out_ready (smo_ready),
        .out_rdata (smo_rdata),
        .out_err   (smo_err)
    );

    // inbound responses
    always_comb begin
        code_ready = 1'b1;
        code_rdata = '0;
        code_err   = 1'b0;
        if (c_rt_bad) begin
            code_err = 1'b1;
        end else if (c_rt_bank) begin
            code_ready = bk_cpu_gnt[0];
            code_rdata = bk_rdata[0];
        end else if (c_rt_cache) begin
            code_rdata = code_cache_rdata;
        end else if (c_rt_out) begin
            code_ready = cf_ready;
            code_rdata = cf_rdata;
            code_err   = cf_ready && cf_err;
        end

        sys_ready = 1'b1;
        sys_rdata = '0;
        sys_err   = 1'b0;
        if (s_rt_bad) begin
            sys_err = 1'b1;
        end else if (s_rt_bank) begin
            sys_ready = bk_cpu_gnt[1];
            sys_rdata = bk_rdata[1];
        end else if (s_rt_out) begin
            sys_ready = sf_ready;
            sys_rdata = sf_rdata;
            sys_err   = sf_ready && sf_err;
        end

        bd_ready = 1'b1;
        bd_rdata = '0;
        bd_err   = 1'b0;
        if (b_rt_bad) begin
            bd_err = 1'b1;
        end else if (bd_req && b_lo) begin
            bd_ready = bk_bd_gnt[0];
            bd_rdata = bk_rdata[0];
        end else if (bd_req && b_up) begin
            bd_ready = bk_bd_gnt[1];
            bd_rdata = bk_rdata[1];
        end
    end

    // R2
    code_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_req && c_lo) |=> !cmo_req);

    // R3
    sys_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_req && s_up) |=> !smo_req);

endmodule

// File: tb/lmr_router_bench.sv
`timescale 1ns/1ps
module lmr_router_bench;

    localparam logic [31:0] SPLIT = 32'h2000_0000;
    localparam logic [31:0] BB    = 32'h0000_1000;
    localparam logic [31:0] LO    = SPLIT - BB;
    localparam logic [31:0] HI    = SPLIT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        code_req = 0, code_write = 0, code_cacheable = 0, code_cache_hit = 0;
    logic [31:0] code_addr = 0, code_wdata = 0, code_cache_rdata = 0;
    logic [2:0]  code_size = 0;
    logic        code_ready, code_err;
    logic [31:0] code_rdata;
    logic        sys_req = 0, sys_write = 0;
    logic [31:0] sys_addr = 0, sys_wdata = 0;
    logic [2:0]  sys_size = 0;
    logic        sys_ready, sys_err;
    logic [31:0] sys_rdata;
    logic        bd_req = 0, bd_write = 0;
    logic [31:0] bd_addr = 0, bd_wdata = 0;
    logic [2:0]  bd_size = 0;
    logic        bd_ready, bd_err;
    logic [31:0] bd_rdata;
    logic        cmo_req, cmo_write, cmo_ready, cmo_err;
    logic [31:0] cmo_addr, cmo_wdata, cmo_rdata;
    logic [2:0]  cmo_size;
    logic        smo_req, smo_write, smo_ready, smo_err;
    logic [31:0] smo_addr, smo_wdata, smo_rdata;
    logic [2:0]  smo_size;

    lmr_router u_lmr_router (.*);

    // outbound slave models
    int cm_wait = 0, sm_wait = 0, cm_cnt = 0, sm_cnt = 0, cm_hs = 0, sm_hs = 0;
    logic [31:0] cm_cap_addr = 0, cm_cap_wdata = 0, sm_cap_addr = 0, sm_cap_wdata = 0;
    logic        cm_cap_write = 0, sm_cap_write = 0;
    logic [2:0]  cm_cap_size = 0, sm_cap_size = 0;

    assign cmo_ready = cmo_req && (cm_cnt >= cm_wait);
    assign cmo_rdata = cmo_addr ^ 32'h5A5A_0F0F;
    assign cmo_err   = (cmo_addr[11:8] == 4'hE);
    assign smo_ready = smo_req && (sm_cnt >= sm_wait);
    assign smo_rdata = smo_addr ^ 32'h3C3C_F0F0;
    assign smo_err   = (smo_addr[11:8] == 4'hE);

    always @(posedge clk) begin
        cm_cnt <= (cmo_req && !cmo_ready) ? cm_cnt + 1 : 0;
        sm_cnt <= (smo_req && !smo_ready) ? sm_cnt + 1 : 0;
        if (cmo_req && cmo_ready) begin
            cm_hs <= cm_hs + 1; cm_cap_addr <= cmo_addr; cm_cap_wdata <= cmo_wdata;
            cm_cap_write <= cmo_write; cm_cap_size <= cmo_size;
        end
        if (smo_req && smo_ready) begin
            sm_hs <= sm_hs + 1; sm_cap_addr <= smo_addr; sm_cap_wdata <= smo_wdata;
            sm_cap_write <= smo_write; sm_cap_size <= smo_size;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench memory model, word keyed
    logic [31:0] mdl [logic [29:0]];

    function automatic void mdl_wr(logic [31:0] a, logic [2:0] sz, logic [31:0] d);
        logic [31:0] w;
        int first, n;
        w = mdl.exists(a[31:2]) ? mdl[a[31:2]] : 32'h0;
        if (sz == 3'd0)      begin first = int'(a[1:0]); n = 1; end
        else if (sz == 3'd1) begin first = a[1] ? 2 : 0; n = 2; end
        else                 begin first = 0; n = 4; end
        for (int l = first; l < first + n; l++) w[8*l +: 8] = d[8*l +: 8];
        mdl[a[31:2]] = w;
    endfunction

    logic [31:0] c_rd, s_rd, b_rd;
    logic        c_er, s_er, b_er;
    int          c_wt, s_wt, b_wt;

    task automatic code_xfer(input logic [31:0] a, input logic wr, input logic [2:0] sz,
                             input logic [31:0] wd, input logic cach, input logic hit,
                             input logic [31:0] crd);
        int w;
        @(negedge clk);
        code_addr = a; code_write = wr; code_size = sz; code_wdata = wd;
        code_cacheable = cach; code_cache_hit = hit; code_cache_rdata = crd; code_req = 1;
        #1; w = 0;
        while (!code_ready) begin @(negedge clk); #1; w++; end
        c_rd = code_rdata; c_er = code_err; c_wt = w;
        @(posedge clk); #1; code_req = 0;
    endtask

    task automatic sys_xfer(input logic [31:0] a, input logic wr, input logic [2:0] sz,
                            input logic [31:0] wd);
        int w;
        @(negedge clk);
        sys_addr = a; sys_write = wr; sys_size = sz; sys_wdata = wd; sys_req = 1;
        #1; w = 0;
        while (!sys_ready) begin @(negedge clk); #1; w++; end
        s_rd = sys_rdata; s_er = sys_err; s_wt = w;
        @(posedge clk); #1; sys_req = 0;
    endtask

    task automatic bd_xfer(input logic [31:0] a, input logic wr, input logic [2:0] sz,
                           input logic [31:0] wd);
        int w;
        @(negedge clk);
        bd_addr = a; bd_write = wr; bd_size = sz; bd_wdata = wd; bd_req = 1;
        #1; w = 0;
        while (!bd_ready) begin @(negedge clk); #1; w++; end
        b_rd = bd_rdata; b_er = bd_err; b_wt = w;
        @(posedge clk); #1; bd_req = 0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        summary();
    end

    logic [31:0] addr, pat;
    int hs0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 code_ready", 32'(code_ready), 1);
        chk("R1 sys_ready",  32'(sys_ready), 1);
        chk("R1 bd_ready",   32'(bd_ready), 1);
        chk("R1 cmo_req",    32'(cmo_req), 0);
        chk("R1 smo_req",    32'(smo_req), 0);

        // R2 / R3 / R7: sweep both ends of each bank with all sizes and lanes
        for (int k = 0; k < 8; k++) begin
            for (int e = 0; e < 2; e++) begin
                hs0 = cm_hs + sm_hs;
                addr = LO + (e != 0 ? BB - 4 - 32'(k) * 4 : 32'(k) * 4);
                pat  = 32'h1357_9BDF ^ {addr[15:0], addr[15:0]};
                code_xfer(addr, 1, 3'd2, pat, 0, 0, 0);                mdl_wr(addr, 3'd2, pat);
                chk("R2 word write wait", 32'(c_wt), 0);
                code_xfer(addr + 32'(k % 4), 1, 3'd0, ~pat, 0, 0, 0); mdl_wr(addr + 32'(k % 4), 3'd0, ~pat);
                code_xfer(addr + 32'(2 * (k % 2)), 1, 3'd1, pat + 32'h1111_1111, 0, 0, 0);
                mdl_wr(addr + 32'(2 * (k % 2)), 3'd1, pat + 32'h1111_1111);
                code_xfer(addr, 0, 3'd2, 0, 0, 0, 0);
                chk("R2 lower read data", c_rd, mdl[addr[31:2]]);
                chk("R2 lower read wait", 32'(c_wt), 0);
                bd_xfer(addr, 0, 3'd2, 0);
                chk("R7 backdoor lower read", b_rd, mdl[addr[31:2]]);
                chk("R7 backdoor wait", 32'(b_wt), 0);

                addr = HI + (e != 0 ? BB - 4 - 32'(k) * 4 : 32'(k) * 4);
                pat  = 32'h2468_ACE0 ^ {addr[15:0], ~addr[15:0]};
                sys_xfer(addr, 1, 3'd2, pat);                          mdl_wr(addr, 3'd2, pat);
                sys_xfer(addr + 32'((k + 1) % 4), 1, 3'd0, ~pat);     mdl_wr(addr + 32'((k + 1) % 4), 3'd0, ~pat);
                sys_xfer(addr + 32'(2 * ((k + 1) % 2)), 1, 3'd1, pat ^ 32'hFFFF_0000);
                mdl_wr(addr + 32'(2 * ((k + 1) % 2)), 3'd1, pat ^ 32'hFFFF_0000);
                sys_xfer(addr, 0, 3'd2, 0);
                chk("R3 upper read data", s_rd, mdl[addr[31:2]]);
                chk("R3 upper read wait", 32'(s_wt), 0);
                bd_xfer(addr, 1, 3'd0, 32'hA5A5_A5A5);                mdl_wr(addr, 3'd0, 32'hA5A5_A5A5);
                sys_xfer(addr, 0, 3'd2, 0);
                chk("R7 backdoor write seen by system", s_rd, mdl[addr[31:2]]);
                chk("R2 R3 no outbound traffic", 32'(cm_hs + sm_hs), 32'(hs0));
            end
        end

        // R4 cache hit
        hs0 = cm_hs;
        code_xfer(32'h0000_4000, 0, 3'd2, 0, 1, 1, 32'hCAFE_F00D);
        chk("R4 cache data", c_rd, 32'hCAFE_F00D);
        chk("R4 cache wait", 32'(c_wt), 0);
        chk("R4 no forward", 32'(cm_hs), 32'(hs0));

        // R5 code forwarding with various wait states
        for (int w = 0; w < 4; w++) begin
            cm_wait = w;
            hs0 = cm_hs;
            addr = 32'h0000_1230 + 32'(w) * 16;
            code_xfer(addr, 0, 3'd2, 0, 1, 0, 32'h1);
            chk("R5 miss wait", 32'(c_wt), 32'(w + 2));
            chk("R5 miss rdata", c_rd, addr ^ 32'h5A5A_0F0F);
            chk("R5 miss addr", cm_cap_addr, addr);
            chk("R5 one handshake", 32'(cm_hs), 32'(hs0 + 1));
        end
        cm_wait = 1;
        code_xfer(32'h0000_2002, 1, 3'd1, 32'hBEEF_CAFE, 0, 1, 32'h0);
        chk("R5 noncacheable forwarded write", 32'(cm_cap_write), 1);
        chk("R5 size kept", 32'(cm_cap_size), 1);
        chk("R5 wdata kept", cm_cap_wdata, 32'hBEEF_CAFE);
        chk("R5 addr kept", cm_cap_addr, 32'h0000_2002);
        code_xfer(LO - 4, 0, 3'd2, 0, 0, 0, 0);
        chk("R5 just below lower window", cm_cap_addr, LO - 4);
        code_xfer(32'h0000_0E00, 0, 3'd2, 0, 0, 0, 0);
        chk("R5 error passed back", 32'(c_er), 1);

        // R6 system forwarding
        for (int w = 0; w < 3; w++) begin
            sm_wait = w;
            addr = 32'h4000_0010 + 32'(w) * 32'h100;
            sys_xfer(addr, 0, 3'd2, 0);
            chk("R6 miss wait", 32'(s_wt), 32'(w + 2));
            chk("R6 miss rdata", s_rd, addr ^ 32'h3C3C_F0F0);
        end
        sys_xfer(HI + BB, 1, 3'd0, 32'h0000_7700);
        chk("R6 just above upper window", sm_cap_addr, HI + BB);
        chk("R6 write kept", sm_cap_wdata, 32'h0000_7700);
        chk("R6 size kept", 32'(sm_cap_size), 0);
        sys_xfer(32'h2000_1E00, 0, 3'd2, 0);
        chk("R6 error passed back", 32'(s_er), 1);

        // R9 / R10 error paths
        hs0 = cm_hs + sm_hs;
        bd_xfer(HI + BB, 0, 3'd2, 0);
        chk("R9 bd above window err", 32'(b_er), 1);
        chk("R9 bd wait", 32'(b_wt), 0);
        bd_xfer(LO - 4, 1, 3'd2, 32'h1);
        chk("R9 bd below window err", 32'(b_er), 1);
        code_xfer(SPLIT, 0, 3'd2, 0, 1, 1, 0);
        chk("R10 code above split err", 32'(c_er), 1);
        chk("R10 code wait", 32'(c_wt), 0);
        sys_xfer(SPLIT - 4, 0, 3'd2, 0);
        chk("R10 sys below split err", 32'(s_er), 1);
        chk("R9 R10 nothing forwarded", 32'(cm_hs + sm_hs), 32'(hs0));

        // R8 contention on the lower bank
        fork
            begin
                code_xfer(LO + 32'h40, 1, 3'd2, 32'h0BAD_0001, 0, 0, 0);
                chk("R8 code first wait", 32'(c_wt), 0);
                code_xfer(LO + 32'h44, 1, 3'd2, 32'h0BAD_0002, 0, 0, 0);
                chk("R8 code stalled one", 32'(c_wt), 1);
            end
            begin
                bd_xfer(LO + 32'h48, 1, 3'd2, 32'h0BAD_0003);
                chk("R8 backdoor waits one", 32'(b_wt), 1);
            end
        join
        mdl_wr(LO + 32'h40, 3'd2, 32'h0BAD_0001);
        mdl_wr(LO + 32'h44, 3'd2, 32'h0BAD_0002);
        mdl_wr(LO + 32'h48, 3'd2, 32'h0BAD_0003);
        bd_xfer(LO + 32'h44, 0, 3'd2, 0);
        chk("R8 code write landed", b_rd, mdl[(LO + 32'h44) >> 2]);
        code_xfer(LO + 32'h48, 0, 3'd2, 0, 0, 0, 0);
        chk("R8 backdoor write landed", c_rd, mdl[(LO + 32'h48) >> 2]);

        // R8 contention on the upper bank
        fork
            begin
                sys_xfer(HI + 32'h80, 0, 3'd2, 0);
                chk("R8 sys first wait", 32'(s_wt), 0);
                sys_xfer(HI + 32'h84, 0, 3'd2, 0);
                chk("R8 sys stalled one", 32'(s_wt), 1);
            end
            begin
                bd_xfer(HI + 32'h88, 1, 3'd2, 32'h7777_1234);
                chk("R8 upper backdoor waits one", 32'(b_wt), 1);
            end
        join
        mdl_wr(HI + 32'h88, 3'd2, 32'h7777_1234);
        sys_xfer(HI + 32'h88, 0, 3'd2, 0);
        chk("R8 upper backdoor write landed", s_rd, mdl[(HI + 32'h88) >> 2]);

        summary();
    end

endmodule